// File: doc/BRIEF.md
# Serial Converter Link Controller

This block is the host side of a chip-select-framed serial link to a four-channel, 12-bit successive-approximation converter. The converter has no conversion clock of its own. Each frame consists of sixteen serial clocks, and those clocks perform both the data transfer and the conversion. The controller derives the active-low select and the serial clock from the system clock through a fixed half-period divider. It sends a 16-bit control word most-significant bit first and receives a 16-bit reply in the same frame. It then returns the 12-bit sample, tagged with the channel it belongs to, under a one-cycle valid strobe.

Between frames the controller keeps the select line high for a minimum quiet gap. After reset, and after any frame that asked the converter to power down, it also holds a longer wake-up wait before the next frame. It steps a channel counter through a programmed window of channels, so every frame addresses the channel for the following conversion. It checks the channel identifier in each reply against that counter and latches a sticky error on a disagreement. A start request that arrives while the link is occupied is remembered and served as soon as the link is free again.

Top module: `adc_link_ctrl`

## Requirements
- R1: Out of reset, `cs_n_o` and `sclk_o` are high and `busy_o`, `res_valid_o` and `chan_err_o` are low. `sclk_o` is high whenever `cs_n_o` is high.
- R2: While `cs_n_o` is low, `sclk_o` falls exactly 16 times. Each serial clock phase lasts `HALF_DIV` system clocks. The first fall comes `HALF_DIV` cycles after the select falls, and the select rises one phase after the 16th rise.
- R3: `ser_out_o` carries the control word most-significant bit first. Its first bit is present when the select falls, and it changes only with rising serial clock edges. With the default positions, the word is: bit 15 = 1, bits 11:10 = address of the next channel, bits 9:8 = `cfg_pwr_i`, bit 5 = `cfg_span_i`, bit 4 = `cfg_fmt_i`, all other bits 0.
- R4: `ser_in_i` is sampled on each rising serial clock edge, most-significant bit first. After the 16th sample, `res_data_o` holds reply bits 11:0 and `res_valid_o` pulses for one cycle, in the same cycle that `cs_n_o` rises.
- R5: A channel counter starts at 0 and tags each result (`res_chan_o`). The next channel equals `cfg_first_i` when the counter equals `cfg_last_i` or lies outside the window. Otherwise it is the counter plus 1 modulo 4. The window wraps past 3 to 0 when first > last. At the end of each frame the counter takes the address that frame sent.
- R6: `chan_err_o` goes high when the reply's identifier (bits 13:12) differs from the expected tag, or when reply bits 15:14 are not zero. It then stays high until reset.
- R7: Between the rise of `cs_n_o` and the next fall, the select stays high for at least `QUIET_CYC` system clocks.
- R8: After reset, and after a frame whose power field was not 2'b11, the next fall of `cs_n_o` comes at least `PWRUP_CYC` cycles after the previous rise (or after reset release).
- R9: A `start_i` pulse while the controller is occupied causes exactly one further frame, with no new request needed. Several such pulses during one occupied period collapse into that one frame.
- R10: `busy_o` is high from the cycle after an accepted start until the quiet gap has ended and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request for one conversion frame |
| cfg_first_i | input | 2 | First channel of the stepping window |
| cfg_last_i | input | 2 | Last channel of the stepping window |
| cfg_pwr_i | input | 2 | Power field for the control word (2'b11 = stay powered) |
| cfg_span_i | input | 1 | Input span select written into the control word |
| cfg_fmt_i | input | 1 | Output format select (1 = straight binary, 0 = two's complement) |
| ser_in_i | input | 1 | Serial reply from the converter |
| cs_n_o | output | 1 | Active-low frame select; its fall is the sampling instant |
| sclk_o | output | 1 | Serial clock, idle high |
| ser_out_o | output | 1 | Serial control word to the converter |
| busy_o | output | 1 | Frame, wait or pending request in progress |
| res_valid_o | output | 1 | One-cycle strobe for a new result |
| res_data_o | output | 12 | Conversion result |
| res_chan_o | output | 2 | Channel tag of the result |
| chan_err_o | output | 1 | Sticky reply-identifier mismatch |

## Verification
A new start request can arrive in the same cycle that a frame completes and its result is strobed. It can also arrive during any cycle of the quiet or wake-up wait, where it competes with the controller's return to idle. The bench raises `start_i` in the exact cycle that `res_valid_o` is seen high, and at random offsets inside busy periods, sometimes twice in quick succession. The run is judged correct when exactly one extra frame follows, when that frame still respects the quiet and wake-up gaps, and when its control word and channel tag follow the stepping rule.

// File: rtl/alink_pkg.sv
package alink_pkg;
    localparam int WORD_W = 16;
    localparam int DATA_W = 12;
    localparam int CH_W   = 2;
    localparam int PM_W   = 2;
    localparam logic [PM_W-1:0] PM_ON = 2'b11;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAKE  = 2'd1,
        ST_XFER  = 2'd2,
        ST_QUIET = 2'd3
    } lk_state_e;
endpackage

// File: rtl/alink_divider.sv
module alink_divider #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_s;

    div_s q, d;

    always_comb begin
        d = q;
        if (!en_i || q.cnt == DW'(HALF_DIV - 1)) begin
            d.cnt = '0;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    assign tick_o = en_i && (q.cnt == DW'(HALF_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/alink_shifter.sv
module alink_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] word_i,
    input  logic         shift_i,
    input  logic         sdi_i,
    output logic         sdo_o,
    output logic [W-1:0] rx_o
);
    typedef struct packed {
        logic [W-1:0] tx;
        logic [W-1:0] rx;
    } sh_s;

    sh_s q, d;

    always_comb begin
        d = q;
        if (load_i) begin
            d.tx = word_i;
            d.rx = '0;
        end else if (shift_i) begin
            d.tx = {q.tx[W-2:0], 1'b0};
            d.rx = {q.rx[W-2:0], sdi_i};
        end
    end

    assign sdo_o = q.tx[W-1];
    assign rx_o  = q.rx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/alink_chanseq.sv
module alink_chanseq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] first_i,
    input  logic [CW-1:0] last_i,
    input  logic          plan_i,
    input  logic          commit_i,
    output logic [CW-1:0] cur_o,
    output logic [CW-1:0] nxt_o
);
    typedef struct packed {
        logic [CW-1:0] cur;
        logic [CW-1:0] tgt;
    } seq_s;

    seq_s q, d;
    logic in_win;

    always_comb begin
        if (first_i <= last_i) in_win = (q.cur >= first_i) && (q.cur <= last_i);
        else                   in_win = (q.cur >= first_i) || (q.cur <= last_i);
        if (!in_win || q.cur == last_i) nxt_o = first_i;
        else                            nxt_o = q.cur + 1'b1;

        d = q;
        if (plan_i)   d.tgt = nxt_o;
        if (commit_i) d.cur = q.tgt;
    end

    assign cur_o = q.cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/adc_link_ctrl.sv
module adc_link_ctrl
    import alink_pkg::*;
#(
    parameter int HALF_DIV  = 4,
    parameter int QUIET_CYC = 7,
    parameter int PWRUP_CYC = 125,
    parameter int WR_POS    = 15,
    parameter int ADDR_LSB  = 10,
    parameter int PM_LSB    = 8,
    parameter int SPAN_POS  = 5,
    parameter int FMT_POS   = 4,
    parameter int ID_LSB    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CH_W-1:0]   cfg_first_i,
    input  logic [CH_W-1:0]   cfg_last_i,
    input  logic [PM_W-1:0]   cfg_pwr_i,
    input  logic              cfg_span_i,
    input  logic              cfg_fmt_i,
    input  logic              ser_in_i,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              ser_out_o,
    output logic              busy_o,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [CH_W-1:0]   res_chan_o,
    output logic              chan_err_o
);
    localparam int CNT_MAX   = (PWRUP_CYC > QUIET_CYC) ? PWRUP_CYC : QUIET_CYC;
    localparam int CW        = $clog2(CNT_MAX + 1);
    localparam int LAST_EDGE = 2 * WORD_W;
    localparam int EDGE_W    = $clog2(LAST_EDGE + 1);
    localparam logic [WORD_W-1:0] DATA_MASK = WORD_W'({DATA_W{1'b1}});
    localparam logic [WORD_W-1:0] ID_MASK   = WORD_W'({CH_W{1'b1}}) << ID_LSB;

    typedef struct packed {
        lk_state_e         st;
        logic              cs_n;
        logic              sclk;
        logic [EDGE_W-1:0] edge_n;
        logic [CW-1:0]     cnt;
        logic              pend;
        logic              pwr_need;
        logic              vld;
        logic [DATA_W-1:0] data;
        logic [CH_W-1:0]   chan;
        logic              err;
    } ctl_s;

    ctl_s q, d;

    logic              tick;
    logic              go;
    logic              begin_x;
    logic              shift;
    logic              commit;
    logic              reply_bad;
    logic [WORD_W-1:0] tx_word;
    logic [WORD_W-1:0] rx_word;
    logic [CH_W-1:0]   cur_ch;
    logic [CH_W-1:0]   nxt_ch;

    alink_divider #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (q.st == ST_XFER),
        .tick_o (tick)
    );

    alink_shifter #(.W(WORD_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (go),
        .word_i  (tx_word),
        .shift_i (shift),
        .sdi_i   (ser_in_i),
        .sdo_o   (ser_out_o),
        .rx_o    (rx_word)
    );

    alink_chanseq #(.CW(CH_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .first_i  (cfg_first_i),
        .last_i   (cfg_last_i),
        .plan_i   (go),
        .commit_i (commit),
        .cur_o    (cur_ch),
        .nxt_o    (nxt_ch)
    );

    // control word assembled from the live configuration at launch
    always_comb begin
        tx_word                    = '0;
        tx_word[WR_POS]            = 1'b1;
        tx_word[ADDR_LSB +: CH_W]  = nxt_ch;
        tx_word[PM_LSB +: PM_W]    = cfg_pwr_i;
        tx_word[SPAN_POS]          = cfg_span_i;
        tx_word[FMT_POS]           = cfg_fmt_i;
    end

    // reply is malformed when its identifier disagrees or filler bits are set
    assign reply_bad = (rx_word[ID_LSB +: CH_W] != cur_ch)
                     || (|(rx_word & ~(DATA_MASK | ID_MASK)));

    assign go = (q.st == ST_IDLE) && (start_i || q.pend);

    always_comb begin
        d       = q;
        d.vld   = 1'b0;
        begin_x = 1'b0;
        shift   = 1'b0;
        commit  = 1'b0;

        if (q.st != ST_IDLE && start_i) d.pend = 1'b1;

        case (q.st)
            ST_IDLE: begin
                if (go) begin
                    d.pend     = 1'b0;
                    d.pwr_need = (cfg_pwr_i != PM_ON);
                    if (q.pwr_need) begin
                        d.st  = ST_WAKE;
                        d.cnt = '0;
                    end else begin
                        begin_x = 1'b1;
                    end
                end
            end
            ST_WAKE: begin
                if (q.cnt == CW'(PWRUP_CYC - 1)) begin
                    begin_x = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_XFER: begin
                if (tick) begin
                    if (q.edge_n == EDGE_W'(LAST_EDGE)) begin
                        d.cs_n = 1'b1;
                        d.st   = ST_QUIET;
                        d.cnt  = '0;
                        d.vld  = 1'b1;
                        d.data = rx_word[DATA_W-1:0];
                        d.chan = cur_ch;
                        d.err  = q.err | reply_bad;
                        commit = 1'b1;
                    end else if (!q.edge_n[0]) begin
                        d.sclk   = 1'b0;
                        d.edge_n = q.edge_n + 1'b1;
                    end else begin
                        d.sclk   = 1'b1;
                        shift    = 1'b1;
                        d.edge_n = q.edge_n + 1'b1;
                    end
                end
            end
            ST_QUIET: begin
                if (q.cnt == CW'(QUIET_CYC - 1)) begin
                    d.st = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (begin_x) begin
            d.st     = ST_XFER;
            d.cs_n   = 1'b0;
            d.sclk   = 1'b1;
            d.edge_n = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.cs_n     <= 1'b1;
            q.sclk     <= 1'b1;
            q.pwr_need <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n_o      = q.cs_n;
    assign sclk_o      = q.sclk;
    assign busy_o      = (q.st != ST_IDLE) || q.pend;
    assign res_valid_o = q.vld;
    assign res_data_o  = q.data;
    assign res_chan_o  = q.chan;
    assign chan_err_o  = q.err;
endmodule

// File: rtl/alink_checker.sv
module alink_checker #(
    parameter int HALF_DIV  = 4,
    parameter int QUIET_CYC = 7
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sclk_o,
    input logic ser_out_o,
    input logic busy_o,
    input logic res_valid_o,
    input logic chan_err_o
);
    localparam int RW = $clog2(HALF_DIV + 2) + 1;
    localparam int QW = $clog2(QUIET_CYC + 2) + 1;

    logic          sclk_prev_q;
    logic [RW-1:0] run_q;
    logic [QW-1:0] hi_q;
    logic [5:0]    fall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b1;
            run_q       <= RW'(HALF_DIV);
            hi_q        <= QW'(QUIET_CYC);
            fall_q      <= '0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (sclk_o != sclk_prev_q)       run_q <= '0;
            else if (run_q < RW'(HALF_DIV))  run_q <= run_q + 1'b1;
            if (!cs_n_o)                     hi_q <= '0;
            else if (hi_q < QW'(QUIET_CYC))  hi_q <= hi_q + 1'b1;
            if (cs_n_o)                      fall_q <= '0;
            else if (sclk_prev_q && !sclk_o) fall_q <= fall_q + 1'b1;
        end
    end

    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> sclk_o);

    p_sixteen_falls_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (fall_q == 6'd16));

    p_half_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o != sclk_prev_q) |-> (run_q >= RW'(HALF_DIV - 1)));

    p_din_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && !$past(cs_n_o) && !$stable(ser_out_o)) |-> $rose(sclk_o));

    p_valid_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $rose(cs_n_o));

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_err_o |=> chan_err_o);

    p_quiet_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (hi_q >= QW'(QUIET_CYC)));

    p_busy_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> busy_o);
endmodule

bind adc_link_ctrl alink_checker #(
    .HALF_DIV  (HALF_DIV),
    .QUIET_CYC (QUIET_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .ser_out_o   (ser_out_o),
    .busy_o      (busy_o),
    .res_valid_o (res_valid_o),
    .chan_err_o  (chan_err_o)
);

// File: tb/tb_adc_link_ctrl.sv
module tb_adc_link_ctrl;
    localparam int HALF_DIV  = 4;
    localparam int QUIET_CYC = 7;
    localparam int PWRUP_CYC = 125;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  cfg_first_i = 2'd0;
    logic [1:0]  cfg_last_i = 2'd3;
    logic [1:0]  cfg_pwr_i = 2'b11;
    logic        cfg_span_i = 1'b0;
    logic        cfg_fmt_i = 1'b1;
    logic        ser_in_i = 1'b0;
    logic        cs_n_o, sclk_o, ser_out_o, busy_o, res_valid_o, chan_err_o;
    logic [11:0] res_data_o;
    logic [1:0]  res_chan_o;

    always #4 clk = ~clk;

    adc_link_ctrl #(
        .HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC), .PWRUP_CYC(PWRUP_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cfg_first_i(cfg_first_i), .cfg_last_i(cfg_last_i), .cfg_pwr_i(cfg_pwr_i),
        .cfg_span_i(cfg_span_i), .cfg_fmt_i(cfg_fmt_i), .ser_in_i(ser_in_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .ser_out_o(ser_out_o), .busy_o(busy_o),
        .res_valid_o(res_valid_o), .res_data_o(res_data_o), .res_chan_o(res_chan_o),
        .chan_err_o(chan_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int frames_done = 0;
    int cyc = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] next_ch(input logic [1:0] c, input logic [1:0] f,
                                           input logic [1:0] l);
        bit in_w;
        in_w = (f <= l) ? (c >= f && c <= l) : (c >= f || c <= l);
        return (!in_w || c == l) ? f : c + 2'd1;
    endfunction

    function automatic logic [15:0] ctl_word(input logic [1:0] a, input logic [1:0] pm,
                                             input logic sp, input logic fm);
        logic [15:0] w;
        w = '0;
        w[15] = 1'b1;
        w[11:10] = a;
        w[9:8] = pm;
        w[5] = sp;
        w[4] = fm;
        return w;
    endfunction

    always @(negedge clk) cyc++;

    // converter model and bench expectations
    logic [15:0] m_tx, m_rx, exp_word;
    logic [11:0] m_data;
    logic [1:0]  m_addr = 2'd0;
    logic [1:0]  chan_b = 2'd0;
    logic [1:0]  exp_tag;
    bit          m_corrupt = 0, m_corrupt_cur = 0, in_frame = 0, pwr_b = 1, exp_err = 0;
    int          m_k = 0, last_rise = 0;

    always @(negedge cs_n_o) begin
        if (rst_n) begin
            in_frame = 1;
            chk((cyc - last_rise) >= (pwr_b ? PWRUP_CYC : QUIET_CYC),
                pwr_b ? "R8 wake gap" : "R7 quiet gap", cyc - last_rise,
                pwr_b ? PWRUP_CYC : QUIET_CYC);
            pwr_b = (cfg_pwr_i != 2'b11);
            exp_tag = chan_b;
            chan_b = next_ch(chan_b, cfg_first_i, cfg_last_i);
            exp_word = ctl_word(chan_b, cfg_pwr_i, cfg_span_i, cfg_fmt_i);
            m_data = 12'($urandom);
            m_corrupt_cur = m_corrupt;
            m_tx = {2'b00, (m_corrupt_cur ? ~m_addr : m_addr), m_data};
            m_k = 0;
            m_rx = '0;
            ser_in_i = 1'b0;
        end
    end

    always @(negedge sclk_o) begin
        if (in_frame && !cs_n_o) begin
            m_rx = {m_rx[14:0], ser_out_o};
            m_k++;
            if (m_k <= 16) ser_in_i = m_tx[16 - m_k];
        end
    end

    always @(posedge cs_n_o) begin
        if (in_frame) begin
            in_frame = 0;
            last_rise = cyc;
            chk(m_k == 16, "R2 falls per frame", m_k, 16);
            chk(m_rx == exp_word, "R3 control word", int'(m_rx), int'(exp_word));
            if (m_rx[15]) m_addr = m_rx[11:10];
            if (m_corrupt_cur) exp_err = 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && res_valid_o) begin
            frames_done++;
            chk(res_data_o == m_data, "R4 result data", int'(res_data_o), int'(m_data));
            chk(res_chan_o == exp_tag, "R5 channel tag", int'(res_chan_o), int'(exp_tag));
            chk(chan_err_o == exp_err, "R6 error flag", int'(chan_err_o), int'(exp_err));
            chk(cs_n_o == 1'b1, "R4 valid with select rise", int'(cs_n_o), 1);
        end
    end

    task automatic kick();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
    endtask

    task automatic wait_idle(input int tgt);
        @(negedge clk);
        while (busy_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(frames_done == tgt, "R9 frame count", frames_done, tgt);
        chk(busy_o == 1'b0, "R10 idle after gap", int'(busy_o), 0);
    endtask

    task automatic set_cfg(input logic [1:0] f, input logic [1:0] l, input logic [1:0] pm,
                           input logic sp, input logic fm);
        cfg_first_i = f; cfg_last_i = l; cfg_pwr_i = pm; cfg_span_i = sp; cfg_fmt_i = fm;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", frames_done, -1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int tgt;
        void'($urandom(32'd4711));
        tgt = 0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        last_rise = cyc;
        @(negedge clk);
        chk(cs_n_o == 1'b1, "R1 reset select", int'(cs_n_o), 1);
        chk(sclk_o == 1'b1, "R1 reset clock", int'(sclk_o), 1);
        chk(busy_o == 1'b0, "R1 reset busy", int'(busy_o), 0);
        chk(res_valid_o == 1'b0, "R1 reset valid", int'(res_valid_o), 0);
        chk(chan_err_o == 1'b0, "R1 reset error", int'(chan_err_o), 0);

        // first frame after reset needs the wake gap (R8)
        set_cfg(2'd0, 2'd3, 2'b11, 1'b0, 1'b1);
        kick(); tgt++; wait_idle(tgt);

        // single-channel window, R5
        set_cfg(2'd2, 2'd2, 2'b11, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) begin kick(); tgt++; wait_idle(tgt); end

        // wrapping window 3 -> 0 -> 1, R5
        set_cfg(2'd3, 2'd1, 2'b11, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) begin kick(); tgt++; wait_idle(tgt); end

        // shutdown frame then a normal one, R8
        set_cfg(2'd0, 2'd1, 2'b01, 1'b1, 1'b1);
        kick(); tgt++; wait_idle(tgt);
        set_cfg(2'd0, 2'd1, 2'b11, 1'b1, 1'b1);
        kick(); tgt++; wait_idle(tgt);

        // start in the same cycle as the result strobe, R9
        kick(); tgt++;
        while (!res_valid_o) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R9 pending held busy", int'(busy_o), 1);
        tgt++; wait_idle(tgt);

        // random configurations with pending requests, R3 R5 R7 R8 R9
        for (int i = 0; i < 50; i++) begin
            int dly;
            logic [1:0] pm;
            pm = (($urandom % 6) == 0) ? 2'($urandom % 3) : 2'b11;
            set_cfg(2'($urandom), 2'($urandom), pm, 1'($urandom), 1'($urandom));
            kick(); tgt++;
            if (($urandom % 2) == 0) begin
                dly = $urandom_range(0, 120);
                repeat (dly) @(negedge clk);
                kick();
                if (dly < 60) kick();
                tgt++;
            end
            wait_idle(tgt);
        end

        // identifier mismatch, then stickiness, R6
        m_corrupt = 1;
        kick(); tgt++; wait_idle(tgt);
        m_corrupt = 0;
        chk(chan_err_o == 1'b1, "R6 error raised", int'(chan_err_o), 1);
        for (int i = 0; i < 3; i++) begin kick(); tgt++; wait_idle(tgt); end
        chk(chan_err_o == 1'b1, "R6 error sticky", int'(chan_err_o), 1);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule